// File: doc/BRIEF.md
# Serial DAC Control Word Receiver

This block is the digital front end for a pair of 8-bit serial-loaded DACs and an offset-trim control. A host shifts 10-bit words into it over a gated serial clock and a data line. The top two bits of each word name a destination and the low eight bits carry the value. Words for the two DAC channels are held in staging registers. A rising edge on a separate latch strobe then moves both staged codes to the DAC outputs on the same cycle. Words for the trim register take effect as soon as they are accepted.

All serial inputs are oversampled in one system clock domain. A word ends when the serial clock has been quiet for a programmable number of system cycles. The receiver accepts the word only if exactly ten bits arrived in it. It discards words with too few bits without comment. It discards words with too many bits and records the event in a sticky error flag. An active-low power-down input clears the section and keeps it idle.

Top module: `sdac_ctrl_if`

## Requirements
- R1: After reset both DAC outputs are 0x00, the trim outputs are factory mode (select 0), decrement (direction 0) and magnitude 0, and the error flag is 0.
- R2: A word is taken MSB first on rising serial-clock edges. Word bits [9:8] = 01 write bits [7:0] into the channel-0 staging register.
- R3: Word bits [9:8] = 10 write bits [7:0] into the channel-1 staging register.
- R4: The DAC outputs change only on a rising edge of the latch strobe (or on power-down). That edge copies both staging registers to the outputs on the same cycle.
- R5: Word bits [9:8] = 00 load the trim register at once, with no strobe needed: bit 5 gives the user-select output (1 = user trim), bit 4 gives the direction output (1 = increment), and bits [3:0] give the magnitude.
- R6: A word with bits [9:8] = 11 is ignored: the staging registers and the trim register keep their values.
- R7: A word with more than ten bits is discarded and sets the error flag. The flag stays set until reset, even after later valid words.
- R8: A word with fewer than ten bits is discarded and leaves the error flag unchanged.
- R9: A serial-clock gap longer than IDLE_CYCLES system cycles closes a word, so consecutive words separated by such a gap are each accepted.
- R10: While power-down is low, the outputs, the trim register and the staging registers are held at zero. Serial words and latch strobes have no effect.
- R11: Codes are passed through in straight binary: 0x00 and 0xFF appear unchanged on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Gated serial clock, idles low |
| ser_dat | input | 1 | Serial data, sampled on ser_clk rising edges |
| load_stb | input | 1 | Latch strobe, normally low; a rising edge updates both DAC outputs |
| pwr_on_n | input | 1 | Active-low power-down for the section |
| dac0_code | output | 8 | Channel-0 DAC code |
| dac1_code | output | 8 | Channel-1 DAC code |
| trim_user | output | 1 | 1 = user trim, 0 = factory trim |
| trim_incr | output | 1 | 1 = increment, 0 = decrement |
| trim_mag | output | 4 | Trim magnitude |
| frame_err | output | 1 | Sticky flag for a word with more than ten bits |

## Verification
The bench builds the block with IDLE_CYCLES = 16 and two synchronizer stages. A word therefore closes about twenty system cycles after its last bit. Each serial bit lasts eight system cycles, which stays well inside the timeout. With these values the bench can hold a word open across all of its bits and still close it with a short gap. Overrun, short-word, reserved-address and back-to-back cases then each take only a few hundred cycles.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int ADDR_W = 2;
    localparam int TRIM_W = 4;

    localparam logic [ADDR_W-1:0] DST_TRIM = 2'b00;
    localparam logic [ADDR_W-1:0] DST_CH0  = 2'b01;
    localparam logic [ADDR_W-1:0] DST_CH1  = 2'b10;

    typedef struct packed {
        logic              user_sel;
        logic              incr;
        logic [TRIM_W-1:0] mag;
    } trim_t;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int WORD_W      = 10,
    parameter int IDLE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic              overrun
);

    localparam int CNT_W  = $clog2(WORD_W + 2);
    localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0]  OVR_CNT  = CNT_W'(WORD_W + 1);
    localparam logic [IDLE_W-1:0] IDLE_END = IDLE_W'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  bits;
        logic [IDLE_W-1:0] idle;
        logic              valid;
        logic              ovr;
    } shf_t;

    shf_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d           = st_q;
        st_d.valid     = 1'b0;
        st_d.ovr       = 1'b0;
        st_d.sclk_prev = sclk_s;
        rise           = sclk_s & ~st_q.sclk_prev;
        if (!enable) begin
            st_d.shift = '0;
            st_d.bits  = '0;
            st_d.idle  = '0;
        end else if (rise) begin
            st_d.shift = {st_q.shift[WORD_W-2:0], sdat_s};
            if (st_q.bits != OVR_CNT) st_d.bits = st_q.bits + 1'b1;
            st_d.idle  = '0;
        end else if (st_q.bits != '0) begin
            if (st_q.idle == IDLE_END) begin
                st_d.bits  = '0;
                st_d.idle  = '0;
                st_d.valid = (st_q.bits == FULL_CNT);
                st_d.ovr   = (st_q.bits == OVR_CNT);
            end else begin
                st_d.idle  = st_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_valid = st_q.valid;
    assign word       = st_q.shift;
    assign overrun    = st_q.ovr;

    // R8
    word_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> ($past(st_q.bits) == FULL_CNT));

    // R7
    ovr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.valid && st_q.ovr));

endmodule

// File: rtl/sdac_regfile.sv
module sdac_regfile
    import sdac_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    input  logic              overrun,
    input  logic              stb_s,
    output logic [CODE_W-1:0] out0,
    output logic [CODE_W-1:0] out1,
    output trim_t             trim,
    output logic              err
);

    typedef struct packed {
        logic              stb_prev;
        logic [CODE_W-1:0] stage0;
        logic [CODE_W-1:0] stage1;
        logic [CODE_W-1:0] out0;
        logic [CODE_W-1:0] out1;
        trim_t             trim;
        logic              err;
    } reg_t;

    reg_t rf_d, rf_q;
    logic              stb_rise;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] payload;
    logic              unused_hi;

    assign addr      = word[WORD_W-1 -: ADDR_W];
    assign payload   = word[CODE_W-1:0];
    assign unused_hi = ^payload[CODE_W-1:TRIM_W+2];

    always_comb begin
        rf_d          = rf_q;
        rf_d.stb_prev = stb_s;
        stb_rise      = stb_s & ~rf_q.stb_prev;
        if (overrun) rf_d.err = 1'b1;
        if (!pd_n) begin
            rf_d.stage0 = '0;
            rf_d.stage1 = '0;
            rf_d.out0   = '0;
            rf_d.out1   = '0;
            rf_d.trim   = '0;
        end else begin
            if (word_valid) begin
                case (addr)
                    DST_TRIM: begin
                        rf_d.trim.user_sel = payload[TRIM_W+1];
                        rf_d.trim.incr     = payload[TRIM_W];
                        rf_d.trim.mag      = payload[TRIM_W-1:0];
                    end
                    DST_CH0: rf_d.stage0 = payload;
                    DST_CH1: rf_d.stage1 = payload;
                    default: ;
                endcase
            end
            if (stb_rise) begin
                rf_d.out0 = rf_q.stage0;
                rf_d.out1 = rf_q.stage1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign out0 = rf_q.out0;
    assign out1 = rf_q.out1;
    assign trim = rf_q.trim;
    assign err  = rf_q.err;

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rf_q.out0) || !$stable(rf_q.out1)) |-> ($past(stb_rise) || !$past(pd_n)));

    // R10
    pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (rf_q.out0 == '0 && rf_q.out1 == '0 && rf_q.trim == '0));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q.err |=> rf_q.err);

    // R6
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && word_valid && addr == 2'b11) |=>
            ($stable(rf_q.stage0) && $stable(rf_q.stage1) && $stable(rf_q.trim)));

    // R5
    trim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && word_valid && addr == DST_TRIM) |=> (rf_q.trim.mag == $past(payload[TRIM_W-1:0])));

endmodule

// File: rtl/sdac_ctrl_if.sv
module sdac_ctrl_if
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = 10,
    parameter int CODE_W      = 8,
    parameter int IDLE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              load_stb,
    input  logic              pwr_on_n,
    output logic [CODE_W-1:0] dac0_code,
    output logic [CODE_W-1:0] dac1_code,
    output logic              trim_user,
    output logic              trim_incr,
    output logic [TRIM_W-1:0] trim_mag,
    output logic              frame_err
);

    logic [2:0]        raw_in, sync_out;
    logic              word_valid, overrun;
    logic [WORD_W-1:0] word;
    trim_t             trim;

    assign raw_in = {ser_clk, ser_dat, load_stb};

    sdac_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    sdac_shifter #(.WORD_W(WORD_W), .IDLE_CYCLES(IDLE_CYCLES)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (pwr_on_n),
        .sclk_s     (sync_out[2]),
        .sdat_s     (sync_out[1]),
        .word_valid (word_valid),
        .word       (word),
        .overrun    (overrun)
    );

    sdac_regfile #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_n       (pwr_on_n),
        .word_valid (word_valid),
        .word       (word),
        .overrun    (overrun),
        .stb_s      (sync_out[0]),
        .out0       (dac0_code),
        .out1       (dac1_code),
        .trim       (trim),
        .err        (frame_err)
    );

    assign trim_user = trim.user_sel;
    assign trim_incr = trim.incr;
    assign trim_mag  = trim.mag;

    // R1
    rst_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (dac0_code == '0 && dac1_code == '0 && !frame_err && trim_mag == '0));

endmodule

// File: tb/sdac_ctrl_if_test.sv
module sdac_ctrl_if_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, load_stb = 1'b0, pwr_on_n = 1'b1;
    logic [7:0] dac0_code, dac1_code;
    logic       trim_user, trim_incr, frame_err;
    logic [3:0] trim_mag;
    int         checks = 0;
    int         fails  = 0;

    always #5 clk = ~clk;

    sdac_ctrl_if #(.SYNC_STAGES(2), .WORD_W(10), .CODE_W(8), .IDLE_CYCLES(16)) uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .load_stb(load_stb), .pwr_on_n(pwr_on_n),
        .dac0_code(dac0_code), .dac1_code(dac1_code),
        .trim_user(trim_user), .trim_incr(trim_incr), .trim_mag(trim_mag),
        .frame_err(frame_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = val[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
        end
        ser_dat = 1'b0;
        wait_cyc(40);
    endtask

    task automatic pulse_stb();
        load_stb = 1'b1;
        wait_cyc(6);
        load_stb = 1'b0;
        wait_cyc(6);
    endtask

    task automatic t_reset();
        check("R1 dac0", dac0_code, 8'h00);
        check("R1 dac1", dac1_code, 8'h00);
        check("R1 trim", {trim_user, trim_incr, trim_mag}, 6'h00);
        check("R1 err", frame_err, 1'b0);
    endtask

    task automatic t_ch0();
        send_bits(16'b01_1010_0101, 10);
        check("R4 no update before strobe", dac0_code, 8'h00);
        pulse_stb();
        check("R2 dac0", dac0_code, 8'hA5);
        check("R3 dac1 untouched", dac1_code, 8'h00);
    endtask

    task automatic t_ch1_pair();
        send_bits(16'b10_0011_1100, 10);
        send_bits(16'b01_1111_1111, 10);
        check("R4 dac0 held", dac0_code, 8'hA5);
        check("R4 dac1 held", dac1_code, 8'h00);
        pulse_stb();
        check("R11 dac0 full scale", dac0_code, 8'hFF);
        check("R3 dac1", dac1_code, 8'h3C);
        send_bits(16'b01_0000_0000, 10);
        send_bits(16'b10_1111_1111, 10);
        pulse_stb();
        check("R11 dac0 zero", dac0_code, 8'h00);
        check("R11 dac1 full scale", dac1_code, 8'hFF);
    endtask

    task automatic t_trim();
        send_bits(16'b00_0011_0110, 10);
        check("R5 trim user/incr/6", {trim_user, trim_incr, trim_mag}, {1'b1, 1'b1, 4'h6});
        send_bits(16'b00_1110_1001, 10);
        check("R5 trim user/decr/9", {trim_user, trim_incr, trim_mag}, {1'b1, 1'b0, 4'h9});
        check("R5 dac0 unaffected", dac0_code, 8'h00);
    endtask

    task automatic t_reserved();
        send_bits(16'b11_0101_0101, 10);
        pulse_stb();
        check("R6 dac0", dac0_code, 8'h00);
        check("R6 dac1", dac1_code, 8'hFF);
        check("R6 trim", {trim_user, trim_incr, trim_mag}, {1'b1, 1'b0, 4'h9});
    endtask

    task automatic t_short();
        send_bits(16'b01_1100_0, 7);
        pulse_stb();
        check("R8 dac0 unchanged", dac0_code, 8'h00);
        check("R8 no error", frame_err, 1'b0);
    endtask

    task automatic t_overrun();
        send_bits(16'b11_01_0001_0010, 12);
        pulse_stb();
        check("R7 dac0 unchanged", dac0_code, 8'h00);
        check("R7 error set", frame_err, 1'b1);
        send_bits(16'b01_0111_0111, 10);
        pulse_stb();
        check("R7 good word after overrun", dac0_code, 8'h77);
        check("R7 error sticky", frame_err, 1'b1);
    endtask

    task automatic t_back2back();
        send_bits(16'b01_1000_0001, 10);
        send_bits(16'b10_0100_0010, 10);
        pulse_stb();
        check("R9 first word", dac0_code, 8'h81);
        check("R9 second word", dac1_code, 8'h42);
    endtask

    task automatic t_powerdown();
        pwr_on_n = 1'b0;
        wait_cyc(4);
        check("R10 dac0 cleared", dac0_code, 8'h00);
        check("R10 dac1 cleared", dac1_code, 8'h00);
        check("R10 trim cleared", {trim_user, trim_incr, trim_mag}, 6'h00);
        send_bits(16'b01_1100_1100, 10);
        send_bits(16'b00_0011_1111, 10);
        pulse_stb();
        check("R10 ignored dac0", dac0_code, 8'h00);
        check("R10 ignored trim", {trim_user, trim_incr, trim_mag}, 6'h00);
        pwr_on_n = 1'b1;
        wait_cyc(4);
        pulse_stb();
        check("R10 staging cleared dac0", dac0_code, 8'h00);
        check("R10 staging cleared dac1", dac1_code, 8'h00);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_ch0();
        t_ch1_pair();
        t_trim();
        t_reserved();
        t_short();
        t_overrun();
        t_back2back();
        t_powerdown();
        finish_run();
    end

endmodule